// File: doc/BRIEF.md
# Single-Bit Asynchronous SRAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM that holds 65,536 one-bit words. The host offers one access at a time through a valid/ready pair carrying a 16-bit address, a write flag and a write bit. The block registers these, drives the RAM's address, data-in, active-low chip enable and active-low write enable pins from flops, and keeps them steady for as many clock cycles as the RAM's nanosecond limits require. Reads come back on a one-cycle response strobe together with the sampled bit.

All cycle counts come from the clock period and the RAM limits through parameters, each rounded up to whole cycles. Between accesses the chip enable is taken high, which puts the RAM into its low-power deselected state. A read that is accepted in the very first idle cycle after a write gets extra cycles with the RAM deselected before its access window opens, so that the RAM's data output has fully re-enabled before it is sampled.

Top module: `sram1b_ctrl`

## Requirements
- R1: After reset, chip enable and write enable are both high, the request ready is high and the response strobe is low.
- R2: A write holds chip enable and write enable low together for WR_CYC cycles, the larger of the rounded-up write pulse and data setup limits (2 cycles, 16 ns at 125 MHz); address and write bit stay unchanged across that whole overlap.
- R3: A write is ended by write enable rising while chip enable is still low; chip enable rises one clock later, and neither address nor data-in changes within one clock after write enable rises.
- R4: A read drives chip enable low with write enable high for RD_CYC cycles, the rounded-up address-to-data limit (2 cycles at 125 MHz), and samples the RAM output at the end of the last of them.
- R5: Each read yields exactly one single-cycle response strobe, RD_CYC cycles after the accepting clock edge when no recovery gap applies; writes yield no response.
- R6: A read accepted on the clock edge that ends the first idle cycle after a write is delayed by GAP_CYC cycles (the rounded-up output re-enable limit, 1 cycle at 125 MHz) with chip enable high, so its response comes RD_CYC+GAP_CYC cycles after acceptance; a read accepted any later gets no delay.
- R7: While chip enable stays low from one cycle to the next, the RAM address does not change.
- R8: Whenever the block is idle and ready for a request, chip enable is high.
- R9: A read returns the bit most recently written to the same address, across all 16 address bits.
- R10: Write enable is never low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_addr | input | 16 | Word address of the access |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wbit | input | 1 | Bit to store on a write |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_bit | output | 1 | Bit read from the RAM |
| ram_addr | output | 16 | RAM address pins |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_din | output | 1 | Bit driven into the RAM |
| ram_dout | input | 1 | Bit driven by the RAM |

## Verification
A timed RAM model in the bench returns the inverse of the stored bit until the access time has elapsed after any address or enable change, so sampling too early shows up as wrong data, and it checks pulse width, setup and hold at the rising edge that ends every write. Back-to-back writes followed at once by a read separate the recovery-gap latency from the plain read latency, while reads issued after an idle cycle show that the gap is not added when no write precedes. Walking-one and walking-zero addresses with opposite data written to each expose any stuck or aliased address bit, and the extremes 0x0000 and 0xFFFF plus an overwrite confirm the latest write wins.

// File: rtl/sram1b_pkg.sv
`timescale 1ns/1ps
package sram1b_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GAP   = 3'd1,
    S_READ  = 3'd2,
    S_WRITE = 3'd3,
    S_WHOLD = 3'd4
  } seq_state_e;

  // Whole clock cycles needed to cover a limit in ns; never less than one.
  function automatic int cyc_ceil(input int ns, input int clk_ns);
    int r;
    r = (ns + clk_ns - 1) / clk_ns;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold values 0..n.
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w = w + 1;
    return w;
  endfunction

endpackage

// File: rtl/sram1b_timer.sv
`timescale 1ns/1ps
module sram1b_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram1b_seq.sv
`timescale 1ns/1ps
module sram1b_seq
  import sram1b_pkg::*;
#(
  parameter int RD_CYC  = 2,
  parameter int WR_CYC  = 2,
  parameter int GAP_CYC = 1,
  parameter int CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          tm_done,
  output logic          tm_load,
  output logic [CW-1:0] tm_val,
  output logic          ready,
  output logic          accept,
  output logic          sample,
  output logic          ce_n,
  output logic          we_n
);

  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LD  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC - 1);

  seq_state_e st_q, st_d;
  logic       wr_recent_q;
  logic       ce_n_q, we_n_q;
  logic       ce_n_d, we_n_d;
  logic [CW:0] lowlen_q;

  assign ready  = (st_q == S_IDLE);
  assign accept = req_valid && ready;
  assign sample = (st_q == S_READ) && tm_done;

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          tm_load = 1'b1;
          if (req_we) begin
            st_d   = S_WRITE;
            tm_val = WR_LD;
          end else if (wr_recent_q) begin
            st_d   = S_GAP;
            tm_val = GAP_LD;
          end else begin
            st_d   = S_READ;
            tm_val = RD_LD;
          end
        end
      end
      S_GAP: begin
        if (tm_done) begin
          st_d    = S_READ;
          tm_load = 1'b1;
          tm_val  = RD_LD;
        end
      end
      S_READ:  if (tm_done) st_d = S_IDLE;
      S_WRITE: if (tm_done) st_d = S_WHOLD;
      S_WHOLD: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign ce_n_d = !((st_d == S_READ) || (st_d == S_WRITE) || (st_d == S_WHOLD));
  assign we_n_d = !(st_d == S_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      wr_recent_q <= 1'b0;
      ce_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
    end else begin
      st_q        <= st_d;
      wr_recent_q <= (st_q == S_WHOLD);
      ce_n_q      <= ce_n_d;
      we_n_q      <= we_n_d;
    end
  end

  // Length of the current write-enable low pulse, for the checks below.
  always_ff @(posedge clk) begin
    if (!rst_n)       lowlen_q <= '0;
    else if (!we_n_q) lowlen_q <= lowlen_q + 1'b1;
    else              lowlen_q <= '0;
  end

  assign ce_n = ce_n_q;
  assign we_n = we_n_q;

  // R10: write strobe only inside chip enable
  a_r10_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !ce_n_q);

  // R3: chip enable rises only after write enable was already high
  a_r3_ce_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n_q) |-> $past(we_n_q));

  // R2: write pulse spans exactly the configured cycle count
  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (lowlen_q == (CW+1)'(WR_CYC)));

  // R6: recovery gap only entered straight after a write's first idle cycle
  a_r6_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == S_GAP) |-> $past(wr_recent_q) && ce_n_q);

endmodule

// File: rtl/sram1b_datapath.sv
`timescale 1ns/1ps
module sram1b_datapath #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic          in_wbit,
  input  logic          sample,
  input  logic          ram_dout,
  output logic [AW-1:0] ram_addr,
  output logic          ram_din,
  output logic          rsp_valid,
  output logic          rsp_bit
);

  logic [AW-1:0] addr_q;
  logic          din_q;
  logic          rv_q, rb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= 1'b0;
    end else if (load) begin
      addr_q <= in_addr;
      din_q  <= in_wbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rb_q <= 1'b0;
    end else begin
      rv_q <= sample;
      if (sample) rb_q <= ram_dout;
    end
  end

  assign ram_addr  = addr_q;
  assign ram_din   = din_q;
  assign rsp_valid = rv_q;
  assign rsp_bit   = rb_q;

  // R5: response strobe never lasts two cycles
  a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);

  // R9: returned bit holds until the next sampled read
  a_r9_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample) |-> $stable(rb_q));

endmodule

// File: rtl/sram1b_ctrl.sv
`timescale 1ns/1ps
module sram1b_ctrl
  import sram1b_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CLK_NS      = 8,
  parameter int T_ACC_NS    = 15,
  parameter int T_WPULSE_NS = 12,
  parameter int T_DSETUP_NS = 10,
  parameter int T_ORE_NS    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic          req_wbit,
  output logic          rsp_valid,
  output logic          rsp_bit,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_we_n,
  output logic          ram_din,
  input  logic          ram_dout
);

  localparam int RD_CYC  = cyc_ceil(T_ACC_NS, CLK_NS);
  localparam int WR_CYC  = imax(cyc_ceil(T_WPULSE_NS, CLK_NS), cyc_ceil(T_DSETUP_NS, CLK_NS));
  localparam int GAP_CYC = cyc_ceil(T_ORE_NS, CLK_NS);
  localparam int CNT_MAX = imax(RD_CYC, imax(WR_CYC, GAP_CYC));
  localparam int CW      = cnt_width(CNT_MAX);

  logic          tm_load, tm_done;
  logic [CW-1:0] tm_val;
  logic          accept, sample;

  sram1b_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .done     (tm_done)
  );

  sram1b_seq #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .GAP_CYC (GAP_CYC),
    .CW      (CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .tm_done   (tm_done),
    .tm_load   (tm_load),
    .tm_val    (tm_val),
    .ready     (req_ready),
    .accept    (accept),
    .sample    (sample),
    .ce_n      (ram_ce_n),
    .we_n      (ram_we_n)
  );

  sram1b_datapath #(.AW(AW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_addr   (req_addr),
    .in_wbit   (req_wbit),
    .sample    (sample),
    .ram_dout  (ram_dout),
    .ram_addr  (ram_addr),
    .ram_din   (ram_din),
    .rsp_valid (rsp_valid),
    .rsp_bit   (rsp_bit)
  );

  // R7: address frozen while the RAM stays selected
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

  // R8: idle means deselected
  a_r8_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ram_ce_n);

  // R4: sampling happens inside a read window
  a_r4_sample_window: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (!ram_ce_n && ram_we_n));

  // R2: address and write bit steady through the write overlap
  a_r2_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_din)));

endmodule

// File: tb/sram1b_ctrl_tb.sv
`timescale 1ns/1ps
module sram1b_ctrl_tb;

  localparam int CLK_NS = 8;

  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int RD  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int WRP = (12 + CLK_NS - 1) / CLK_NS;
  localparam int WRS = (10 + CLK_NS - 1) / CLK_NS;
  localparam int WR  = (WRP > WRS) ? WRP : WRS;
  localparam int GAP = (5 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic        req_wbit = 1'b0;
  logic        rsp_valid, rsp_bit;
  logic [15:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_din;
  logic        ram_dout_m = 1'b0;

  always #4 clk = ~clk;

  sram1b_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .req_wbit  (req_wbit),
    .rsp_valid (rsp_valid),
    .rsp_bit   (rsp_bit),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_we_n  (ram_we_n),
    .ram_din   (ram_din),
    .ram_dout  (ram_dout_m)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- timed RAM model ----------------
  bit mem[int];
  function automatic bit peek(input int a);
    return mem.exists(a) ? mem[a] : 1'b0;
  endfunction

  int ev_id = 0;
  always @(ram_addr or ram_ce_n or ram_we_n) begin
    ev_id++;
    ram_dout_m = ~peek(int'(ram_addr));
    fork
      begin
        automatic int id = ev_id;
        #15;
        if (id == ev_id && !ram_ce_n && ram_we_n) ram_dout_m = peek(int'(ram_addr));
      end
    join_none
  end

  wire     ov = !ram_ce_n && !ram_we_n;
  realtime t_ov = 0.0, t_addr = 0.0, t_din = 0.0, t_werise = -100.0;
  int      hold_viol = 0;

  always @(ram_addr) begin
    if ($realtime - t_werise < CLK_NS) hold_viol++;
    t_addr = $realtime;
  end
  always @(ram_din) begin
    if ($realtime - t_werise < CLK_NS) hold_viol++;
    t_din = $realtime;
  end
  always @(posedge ov) t_ov = $realtime;
  always @(negedge ov) if (rst_n) begin
    chk(($realtime - t_ov) >= 12.0 && ($realtime - t_din) >= 10.0 && ($realtime - t_addr) >= 12.0,
        "R2", "write pulse/setup ns", int'($realtime - t_ov), 12);
    chk(ram_we_n && !ram_ce_n, "R3", "write ended by we_n with ce_n low", int'(ram_ce_n), 0);
    t_werise = $realtime;
    mem[int'(ram_addr)] = ram_din;
  end

  // ---------------- sampled pin sweeps ----------------
  int r7_viol = 0, r8_viol = 0, r10_viol = 0, r5_viol = 0;
  logic        prev_ce = 1'b1, prev_rsp = 1'b0;
  logic [15:0] prev_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (!ram_ce_n && !prev_ce && ram_addr != prev_addr) r7_viol++;
    if (req_ready && !ram_ce_n) r8_viol++;
    if (!ram_we_n && ram_ce_n) r10_viol++;
    if (rsp_valid && prev_rsp) r5_viol++;
    prev_ce = ram_ce_n; prev_addr = ram_addr; prev_rsp = rsp_valid;
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit d; int due; string tag; } item_t;
  item_t q[$];
  bit    exp_mem[int];
  int    last_wr_acc = -100;

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (q.size() == 0) chk(1'b0, "R5", "response with no read outstanding", 1, 0);
    else begin
      item_t it;
      it = q.pop_front();
      chk(rsp_bit == it.d, it.tag, "read data", int'(rsp_bit), int'(it.d));
      chk(cyc == it.due, it.tag, "response cycle", cyc, it.due);
    end
  end

  task automatic issue(input bit we, input logic [15:0] a, input bit d, input string tag);
    int acc;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wbit = d;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    if (we) begin
      exp_mem[int'(a)] = d;
      last_wr_acc = acc;
    end else begin
      item_t it;
      it.d   = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 1'b0;
      it.due = acc + RD + ((acc == last_wr_acc + WR + 2) ? GAP : 0);
      it.tag = tag;
      q.push_back(it);
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet pins after reset
    chk(ram_ce_n && ram_we_n, "R1", "enables high after reset", int'({ram_ce_n, ram_we_n}), 3);
    chk(req_ready && !rsp_valid, "R1", "ready high, strobe low", int'({req_ready, rsp_valid}), 2);

    // extremes and alternating patterns, back to back
    issue(1'b1, 16'h0000, 1'b1, "R2");
    issue(1'b1, 16'hFFFF, 1'b0, "R2");
    issue(1'b1, 16'h5555, 1'b1, "R2");
    issue(1'b1, 16'hAAAA, 1'b0, "R2");
    // R6: read right after a write gets the recovery gap
    issue(1'b0, 16'h0000, 1'b0, "R6");
    issue(1'b0, 16'hFFFF, 1'b0, "R9");
    issue(1'b0, 16'h5555, 1'b0, "R9");
    issue(1'b0, 16'hAAAA, 1'b0, "R4");

    // R6 negative: an idle cycle after the write removes the gap
    idle(3);
    issue(1'b1, 16'h1234, 1'b1, "R2");
    idle(2);
    issue(1'b0, 16'h1234, 1'b0, "R4");
    idle(2);

    // R9: walking one and walking zero addresses with opposite data
    for (int i = 0; i < 16; i++) begin
      issue(1'b1, 16'(1 << i), bit'(i & 1), "R2");
      issue(1'b1, ~16'(1 << i), ~bit'(i & 1), "R2");
    end
    for (int i = 0; i < 16; i++) begin
      issue(1'b0, 16'(1 << i), 1'b0, "R9");
      issue(1'b0, ~16'(1 << i), 1'b0, "R9");
    end

    // R9: overwrite wins; immediate read gets gap (R6)
    issue(1'b1, 16'h0000, 1'b0, "R2");
    issue(1'b0, 16'h0000, 1'b0, "R6");
    issue(1'b1, 16'hFFFF, 1'b1, "R2");
    idle(1);
    issue(1'b0, 16'hFFFF, 1'b0, "R9");
    idle(RD + GAP + 6);

    chk(q.size() == 0, "R5", "all reads answered", q.size(), 0);
    chk(hold_viol == 0, "R3", "addr/din hold after we_n rise", hold_viol, 0);
    chk(r7_viol == 0, "R7", "addr stable while selected", r7_viol, 0);
    chk(r8_viol == 0, "R8", "deselected while idle", r8_viol, 0);
    chk(r10_viol == 0, "R10", "we_n low only with ce_n low", r10_viol, 0);
    chk(r5_viol == 0, "R5", "strobe single cycle", r5_viol, 0);
    report();
    $finish;
  end

endmodule